// File: doc/BRIEF.md
# Rotating Priority Resolver with End-of-Interrupt Handling

This block is the arbitration core of an eight-level interrupt controller. It keeps the in-service register and a rotating priority base. From the request, mask and in-service state it finds the request that should be delivered to the processor next. Pending and the winning level are formed combinationally, so any change in requests, masks, in-service bits or base shows up on the outputs in the same cycle.

A register decoder in front of the block supplies the mask bits, the mode flags and the end-of-interrupt commands. An acknowledge sequencer pulses the set-in-service strobe when the processor accepts an interrupt. The sequencer pulses the automatic end-of-interrupt request when that mode applies. Commands can clear an in-service bit, either one named by level or the highest-priority one found by a search. They can also rotate priority so that the serviced level drops to the bottom. One command form only records whether automatic end-of-interrupt should also rotate.

Top module: `prio_resolve`

## Requirements
- R1: The scan visits levels in the order (base + i) mod N for i = 0..N-1. The first visited level has the highest priority, and the winner is the first eligible level in that order.
- R2: A level is eligible only when its request bit is 1, its mask bit is 0 and its in-service bit is 0 (R4 gives the exception). While `init_busy` is 1, no level is eligible.
- R3: With `smm` = 0, the scan ends with no winner when it reaches a level whose in-service bit is 1. All lower priorities are blocked.
- R4: With `smm` = 1, in-service levels do not block the scan. With `sfnm` = 1, a level whose `casc_mask` bit is 1 stays eligible while in service. If it is not requested and `smm` = 0, the scan still ends there.
- R5: When there is no winner, `int_pend` is 0 and `int_lvl` reads N-1.
- R6: When `set_is` is 1 and `int_pend` is 1, the in-service bit of `int_lvl` is set at the next clock edge. When `int_pend` is 0, `set_is` has no effect.
- R7: A command with `cmd_sel` or `cmd_eoi` set picks a target. The target is `cmd_lvl` when `cmd_sel` = 1. Otherwise it is the highest-priority level whose in-service bit is 1, and if no such level exists nothing changes. `cmd_eoi` = 1 clears the target's in-service bit. `cmd_rot` = 1 sets the base to (target + 1) mod N. With no command, no automatic request and no strobe, the in-service bits and the base hold.
- R8: A command with `cmd_sel` = 0 and `cmd_eoi` = 0 stores `cmd_rot` into `aeoi_rot`. The in-service bits and the base are left unchanged.
- R9: `aeoi_req` = 1 (with no command in that cycle) clears the in-service bit found by the search of R7. When `aeoi_rot` = 1 it also sets the base to that level + 1 mod N.
- R10: With `smm` = 1, the search of R7 and R9 skips in-service levels whose mask bit is 1.
- R11: After reset, the in-service bits are 0, the base is 0 and `aeoi_rot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irr | input | N | Request bits per level |
| imr | input | N | Mask bits per level |
| smm | input | 1 | Special mask mode |
| sfnm | input | 1 | Special fully nested mode |
| casc_mask | input | N | Levels that are cascade inputs |
| init_busy | input | 1 | Initialization in progress; blocks all requests |
| cmd_valid | input | 1 | Command strobe |
| cmd_rot | input | 1 | Command rotate bit |
| cmd_sel | input | 1 | Command select-level bit |
| cmd_eoi | input | 1 | Command end-of-interrupt bit |
| cmd_lvl | input | W | Command level for select-level commands |
| aeoi_req | input | 1 | Automatic end-of-interrupt request |
| set_is | input | 1 | Mark the current winner in service |
| int_pend | output | 1 | An eligible request exists |
| int_lvl | output | W | Winning level, N-1 when none |
| isr | output | N | In-service bits |
| base | output | W | Current priority base |
| aeoi_rot | output | 1 | Rotate-in-automatic-EOI flag |

## Verification
The assertions assume that `cmd_valid`, `aeoi_req` and `set_is` are never high in the same cycle. They also assume that every input is stable between clock edges. The random stimulus chooses at most one of the three actions per cycle. It changes inputs only at the falling edge. Requests, masks, mode flags and the cascade mask vary freely, so in-service bits build up through the strobe and are cleared by every command form.

// File: rtl/prio_resolve.sv
module prio_resolve #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irr,
  input  logic [N-1:0] imr,
  input  logic         smm,
  input  logic         sfnm,
  input  logic [N-1:0] casc_mask,
  input  logic         init_busy,
  input  logic         cmd_valid,
  input  logic         cmd_rot,
  input  logic         cmd_sel,
  input  logic         cmd_eoi,
  input  logic [W-1:0] cmd_lvl,
  input  logic         aeoi_req,
  input  logic         set_is,
  output logic         int_pend,
  output logic [W-1:0] int_lvl,
  output logic [N-1:0] isr,
  output logic [W-1:0] base,
  output logic         aeoi_rot
);

  logic [N-1:0] isr_q, isr_d, clr_m, set_m;
  logic [W-1:0] base_q, base_d;
  logic         aeoi_q, aeoi_d;

  logic         win_hit, win_done;
  logic [W-1:0] win_lvl, sc_idx;
  logic         sc_cas;

  logic         ns_hit;
  logic [W-1:0] ns_lvl, ns_idx;

  logic         tgt_ok;
  logic [W-1:0] tgt;

  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] a, input int b);
    return W'((int'(a) + b) % N);
  endfunction

  always_comb begin
    win_hit  = 1'b0;
    win_done = 1'b0;
    win_lvl  = W'(N - 1);
    sc_idx   = '0;
    sc_cas   = 1'b0;
    for (int i = 0; i < N; i++) begin
      sc_idx = wrap_add(base_q, i);
      sc_cas = sfnm && casc_mask[sc_idx];
      if (!win_done) begin
        if (isr_q[sc_idx] && !smm && !sc_cas) begin
          win_done = 1'b1;
        end else if (!init_busy && irr[sc_idx] && !imr[sc_idx] &&
                     (!isr_q[sc_idx] || sc_cas)) begin
          win_hit  = 1'b1;
          win_lvl  = sc_idx;
          win_done = 1'b1;
        end else if (isr_q[sc_idx] && !smm) begin
          win_done = 1'b1;
        end
      end
    end
  end

  assign int_pend = win_hit;
  assign int_lvl  = win_lvl;

  always_comb begin
    ns_hit = 1'b0;
    ns_lvl = '0;
    ns_idx = '0;
    for (int i = 0; i < N; i++) begin
      ns_idx = wrap_add(base_q, i);
      if (!ns_hit && isr_q[ns_idx] && (!smm || !imr[ns_idx])) begin
        ns_hit = 1'b1;
        ns_lvl = ns_idx;
      end
    end
  end

  always_comb begin
    clr_m  = '0;
    set_m  = '0;
    base_d = base_q;
    aeoi_d = aeoi_q;
    tgt_ok = 1'b0;
    tgt    = cmd_sel ? cmd_lvl : ns_lvl;
    if (cmd_valid) begin
      if (cmd_sel || cmd_eoi) begin
        tgt_ok = cmd_sel || ns_hit;
        if (tgt_ok) begin
          if (cmd_eoi) clr_m[tgt] = 1'b1;
          if (cmd_rot) base_d = wrap_add(tgt, 1);
        end
      end else begin
        aeoi_d = cmd_rot;
      end
    end else if (aeoi_req && ns_hit) begin
      clr_m[ns_lvl] = 1'b1;
      if (aeoi_q) base_d = wrap_add(ns_lvl, 1);
    end
    if (set_is && win_hit) set_m[win_lvl] = 1'b1;
    isr_d = (isr_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
      aeoi_q <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      base_q <= base_d;
      aeoi_q <= aeoi_d;
    end
  end

  assign isr      = isr_q;
  assign base     = base_q;
  assign aeoi_rot = aeoi_q;

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend |-> (irr[int_lvl] && !imr[int_lvl] && !init_busy)); // R2
  AST_WIN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && !(sfnm && casc_mask[int_lvl])) |-> !isr_q[int_lvl]); // R4
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !int_pend |-> (int_lvl == W'(N - 1))); // R5
  AST_SET_IS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_is && int_pend && !cmd_valid && !aeoi_req) |=> isr_q[$past(int_lvl)]); // R6
  AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sel && cmd_eoi && !set_is) |=> !isr_q[$past(cmd_lvl)]); // R7
  AST_SPEC_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sel && cmd_rot) |=> (base_q == wrap_add($past(cmd_lvl), 1))); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !aeoi_req && !set_is) |=> ($stable(isr_q) && $stable(base_q))); // R7
  AST_AEOI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_sel && !cmd_eoi) |=> (aeoi_q == $past(cmd_rot) && $stable(base_q))); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_valid, aeoi_req, set_is}) <= 1); // R9

endmodule

// File: tb/test_prio_resolve.sv
module test_prio_resolve;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [7:0] irr = 0, imr = 0, casc_mask = 0;
  logic smm = 0, sfnm = 0, init_busy = 0;
  logic cmd_valid = 0, cmd_rot = 0, cmd_sel = 0, cmd_eoi = 0;
  logic [2:0] cmd_lvl = 0;
  logic aeoi_req = 0, set_is = 0;
  logic int_pend;
  logic [2:0] int_lvl, base;
  logic [7:0] isr;
  logic aeoi_rot;

  int n_checks = 0, n_fail = 0;

  bit [7:0] m_isr, n_isr;
  int m_base, n_base;
  bit m_aeoi, n_aeoi;
  bit e_pend;
  int e_lvl;

  prio_resolve #(.N(N)) i_prio_resolve (
    .clk(clk), .rst_n(rst_n), .irr(irr), .imr(imr), .smm(smm), .sfnm(sfnm),
    .casc_mask(casc_mask), .init_busy(init_busy), .cmd_valid(cmd_valid),
    .cmd_rot(cmd_rot), .cmd_sel(cmd_sel), .cmd_eoi(cmd_eoi), .cmd_lvl(cmd_lvl),
    .aeoi_req(aeoi_req), .set_is(set_is), .int_pend(int_pend), .int_lvl(int_lvl),
    .isr(isr), .base(base), .aeoi_rot(aeoi_rot));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: walk priority order, stop on blocking in-service levels.
  task automatic model_scan();
    int lv;
    bit cas;
    e_pend = 0; e_lvl = N - 1;
    for (int k = 0; k < N; k++) begin
      lv = (m_base + k) % N;
      cas = sfnm && casc_mask[lv];
      if (m_isr[lv] && !smm && !cas) return;
      if (!init_busy && irr[lv] && !imr[lv] && (!m_isr[lv] || cas)) begin
        e_pend = 1; e_lvl = lv; return;
      end
      if (m_isr[lv] && !smm) return;
    end
  endtask

  function automatic int model_search();
    int lv;
    for (int k = 0; k < N; k++) begin
      lv = (m_base + k) % N;
      if (m_isr[lv] && (!smm || !imr[lv])) return lv;
    end
    return -1;
  endfunction

  task automatic model_next();
    int t;
    n_isr = m_isr; n_base = m_base; n_aeoi = m_aeoi;
    if (cmd_valid) begin
      if (cmd_sel || cmd_eoi) begin
        t = cmd_sel ? int'(cmd_lvl) : model_search();
        if (t >= 0) begin
          if (cmd_eoi) n_isr[t] = 0;
          if (cmd_rot) n_base = (t + 1) % N;
        end
      end else n_aeoi = cmd_rot;
    end else if (aeoi_req) begin
      t = model_search();
      if (t >= 0) begin
        n_isr[t] = 0;
        if (m_aeoi) n_base = (t + 1) % N;
      end
    end
    if (set_is && e_pend) n_isr[e_lvl] = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_isr <= 0; m_base <= 0; m_aeoi <= 0;
    end else begin
      m_isr <= n_isr; m_base <= n_base; m_aeoi <= n_aeoi;
    end
  end

  // op: 0 idle, 1 command, 2 auto EOI, 3 set in service; cmd = {rot, sel, eoi, lvl[2:0]}
  task automatic cyc(input logic [7:0] r, input logic [7:0] m, input logic [2:0] fl,
                     input logic [7:0] cm, input int op, input logic [5:0] cmd);
    @(negedge clk);
    irr = r; imr = m; {smm, sfnm, init_busy} = fl; casc_mask = cm;
    cmd_valid = (op == 1); aeoi_req = (op == 2); set_is = (op == 3);
    {cmd_rot, cmd_sel, cmd_eoi, cmd_lvl} = cmd;
    #1;
    model_scan();
    check("R2 pend", int_pend, e_pend);
    check("R1 level", int_lvl, e_lvl);
    check("R6 isr", isr, m_isr);
    check("R7 base", base, m_base);
    check("R8 aeoi flag", aeoi_rot, m_aeoi);
    model_next();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    cyc(8'h00, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R11 isr", isr, 0); check("R11 base", base, 0); check("R11 aeoi", aeoi_rot, 0);
    check("R5 idle level", int_lvl, 7);

    cyc(8'h24, 8'h00, 3'b000, 8'h00, 3, 6'h00);
    check("R1 winner", int_lvl, 2);
    cyc(8'h24, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R3 blocked", int_pend, 0); check("R5 level", int_lvl, 7);
    check("R6 set", isr, 8'h04);
    cyc(8'h24, 8'h00, 3'b100, 8'h00, 0, 6'h00);
    check("R4 smm", int_lvl, 5);
    cyc(8'h04, 8'h00, 3'b010, 8'h04, 0, 6'h00);
    check("R4 sfnm", int_lvl, 2); check("R4 sfnm pend", int_pend, 1);
    cyc(8'h20, 8'h00, 3'b100, 8'h00, 3, 6'h00);
    check("R4 smm winner", int_lvl, 5);
    cyc(8'h00, 8'h04, 3'b100, 8'h00, 1, 6'b001000);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R10 skip masked", isr, 8'h04);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 1, 6'b111010);
    cyc(8'h0C, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R7 clear", isr, 0); check("R7 rotate", base, 3);
    check("R1 rotated order", int_lvl, 3);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 1, 6'b100000);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R8 flag", aeoi_rot, 1); check("R8 base kept", base, 3);
    cyc(8'h01, 8'h00, 3'b000, 8'h00, 3, 6'h00);
    check("R1 wrap", int_lvl, 0);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 2, 6'h00);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R9 clear", isr, 0); check("R9 rotate", base, 1);
    cyc(8'hFF, 8'h00, 3'b001, 8'h00, 0, 6'h00);
    check("R2 init blocks", int_pend, 0);
    cyc(8'h02, 8'h02, 3'b000, 8'h00, 3, 6'h00);
    check("R2 masked", int_pend, 0);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R6 ignored", isr, 0);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 1, 6'b101000);
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 0, 6'h00);
    check("R7 empty search", base, 1);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r, m, cm;
      logic [2:0] fl;
      int op, sel;
      r  = 8'($urandom);
      m  = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      cm = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      fl = {($urandom % 4 == 0), ($urandom % 3 == 0), ($urandom % 20 == 0)};
      sel = $urandom % 8;
      op = (sel < 3) ? 3 : (sel < 5) ? 1 : (sel == 5) ? 2 : 0;
      cyc(r, m, fl, cm, op, 6'($urandom));
    end
    cyc(8'h00, 8'h00, 3'b000, 8'h00, 0, 6'h00);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule